// File: doc/BRIEF.md
# Host Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from internal sources into a sticky status register and drives one interrupt line toward the host processor. The host sees the block through a plain register bus with an address, a write enable and write word, and a read enable with a registered read word. The bus exposes a direct mask register, atomic mask-set and mask-clear registers, two ways to read status (a side-effect-free peek and a clear-on-read take), a write-one-to-acknowledge register, and a control register that enables the line and picks its polarity.

The status field is `IRQ_W` bits wide (18 by default). A parameter lists the implemented source bits. By default these are 0 to 10, 14, 16 and 17, which cover receive and transmit data and transfer, event mailbox, wake, debug trace, command complete, init complete and coexistence sense changes. Bits 11, 12, 13 and 15 are reserved. The bus carries `DATA_W`-bit words. Status and mask occupy the low `IRQ_W` bits and the bits above them read as zero. The bus has no back-pressure: every access completes in the cycle it is presented.

Register offsets (word addresses): 0 mask, 1 mask-set, 2 mask-clear, 3 status peek, 4 status take, 5 acknowledge, 6 control. Control bit 0 enables the line and control bit 1 selects active-low output when set.

Top module: `hirq_ctrl`

## Requirements
- R1: After reset the mask reads 0x00001, status reads 0, control reads 0 and `irq_o` is 0.
- R2: An event pulse on an implemented bit sets that status bit, and the bit stays set. Events on reserved bits (11, 12, 13, 15 by default) never set status, and those bits read 0.
- R3: A read at offset 3 returns status and leaves it unchanged.
- R4: A read at offset 4 returns status and clears every status bit. An event arriving in the same cycle is kept, and it is not part of the returned word.
- R5: A write at offset 5 clears each status bit written as 1, and the clearing shows in both status views. Bits written as 0 are unaffected. An event on the same bit in the same cycle wins.
- R6: A write at offset 0 loads the mask from the low `IRQ_W` bits of the write word, and offset 0 reads it back. Higher bits are dropped.
- R7: A write at offset 1 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R8: A write at offset 2 clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R9: `irq_o` is asserted when control bit 0 is set and any status bit has its mask bit at 0. Asserted means 1, or 0 when control bit 1 is set. When not asserted, `irq_o` equals control bit 1.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd_en` and is held until the next read. Reads of the write-only offsets 1, 2, 5 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | IRQ_W | Single-cycle source event pulses, one per status bit |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write word |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read word |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The assertions assume that event inputs are already synchronous to `clk` and are held at zero during reset. They also assume that a cycle carries at most one write and at most one read. The peek-stability property only holds when no event, acknowledge or take occurs in the same cycle. The stimulus drives every input on the falling edge, presents each access for a single cycle, and keeps events low except in the directed collision cases, where the event is the point of the test.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

  localparam int unsigned OFF_MASK     = 0;
  localparam int unsigned OFF_MASK_SET = 1;
  localparam int unsigned OFF_MASK_CLR = 2;
  localparam int unsigned OFF_PEEK     = 3;
  localparam int unsigned OFF_TAKE     = 4;
  localparam int unsigned OFF_ACK      = 5;
  localparam int unsigned OFF_CTRL     = 6;

  localparam int unsigned CTRL_W = 2;

  typedef struct packed {
    logic active_low;
    logic enable;
  } hirq_ctrl_t;

  typedef struct packed {
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic ack_wr;
    logic ctrl_wr;
    logic peek_rd;
    logic take_rd;
  } hirq_strobe_t;

endpackage

// File: rtl/hirq_regif.sv
module hirq_regif
  import hirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IRQ_W-1:0]  status,
  input  logic [IRQ_W-1:0]  mask,
  input  hirq_ctrl_t        ctrl,
  output hirq_strobe_t      stb,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned NREG = 7;

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = (addr == ADDR_W'(g));
  end

  always_comb begin
    stb.mask_wr  = wr_en & hit[OFF_MASK];
    stb.mask_set = wr_en & hit[OFF_MASK_SET];
    stb.mask_clr = wr_en & hit[OFF_MASK_CLR];
    stb.ack_wr   = wr_en & hit[OFF_ACK];
    stb.ctrl_wr  = wr_en & hit[OFF_CTRL];
    stb.peek_rd  = rd_en & hit[OFF_PEEK];
    stb.take_rd  = rd_en & hit[OFF_TAKE];
  end

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit[OFF_MASK])                   rd_mux = DATA_W'(mask);
    if (hit[OFF_PEEK] || hit[OFF_TAKE])  rd_mux = DATA_W'(status);
    if (hit[OFF_CTRL])                   rd_mux = DATA_W'(ctrl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10: the read word only moves on a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R10: at most one register strobe per access
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.mask_wr, stb.mask_set, stb.mask_clr, stb.ack_wr, stb.ctrl_wr}));

endmodule

// File: rtl/hirq_mask.sv
module hirq_mask #(
  parameter int unsigned        IRQ_W    = 18,
  parameter logic [IRQ_W-1:0]   MASK_RST = IRQ_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             set,
  input  logic             clr,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= MASK_RST;
    else if (load) mask <= wbits;
    else if (set)  mask <= mask | wbits;
    else if (clr)  mask <= mask & ~wbits;
  end

  // R7: set touches only ones, and they end up set
  a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !load) |=> ((mask & $past(wbits)) == $past(wbits)) &&
                       ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

  // R8: clear touches only ones, and they end up clear
  a_r8_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load && !set) |=> ((mask & $past(wbits)) == '0) &&
                       ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

endmodule

// File: rtl/hirq_status.sv
module hirq_status #(
  parameter int unsigned      IRQ_W = 18,
  parameter logic [IRQ_W-1:0] IMPL  = 18'h347FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt,
  input  logic             ack,
  input  logic [IRQ_W-1:0] ack_bits,
  input  logic             take,
  output logic [IRQ_W-1:0] status
);

  logic [IRQ_W-1:0] evt_ok;
  logic [IRQ_W-1:0] drop;
  logic [IRQ_W-1:0] stat_d;

  assign evt_ok = evt & IMPL;

  always_comb begin
    drop = '0;
    if (ack)  drop = drop | ack_bits;
    if (take) drop = '1;
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      assign stat_d[b] = evt_ok[b] | (status[b] & ~drop[b]);
    end else begin : g_rsvd
      assign stat_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= stat_d;
  end

  // R2: an accepted event is visible the next cycle whatever else happens
  a_r2_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_ok) |=> ((status & $past(evt_ok)) == $past(evt_ok)));

  // R2: reserved positions never hold a one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL) == '0);

  // R4: a take leaves only the same-cycle events
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status == $past(evt_ok)));

  // R5: acknowledged bits drop when no event collides
  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && evt == '0) |=> ((status & $past(ack_bits)) == '0));

endmodule

// File: rtl/hirq_out.sv
module hirq_out
  import hirq_pkg::*;
#(
  parameter int unsigned IRQ_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_bits,
  input  logic [IRQ_W-1:0] status,
  input  logic [IRQ_W-1:0] mask,
  output hirq_ctrl_t       ctrl,
  output logic             irq
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= hirq_ctrl_t'(ctrl_bits);
  end

  assign pending = ctrl.enable & (|(status & ~mask));
  assign irq     = pending ^ ctrl.active_low;

endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
  import hirq_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 4,
  parameter int unsigned      DATA_W   = 32,
  parameter int unsigned      IRQ_W    = 18,
  parameter logic [IRQ_W-1:0] IMPL     = 18'h347FF,
  parameter logic [IRQ_W-1:0] MASK_RST = IRQ_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  evt_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  hirq_strobe_t     stb;
  hirq_ctrl_t       ctrl;
  logic [IRQ_W-1:0] status;
  logic [IRQ_W-1:0] mask;
  logic [IRQ_W-1:0] wbits;

  assign wbits = bus_wdata[IRQ_W-1:0];

  hirq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) regif_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
    .rd_en(bus_rd_en), .status(status), .mask(mask), .ctrl(ctrl),
    .stb(stb), .rdata(bus_rdata)
  );

  hirq_mask #(.IRQ_W(IRQ_W), .MASK_RST(MASK_RST)) mask_i (
    .clk(clk), .rst_n(rst_n), .load(stb.mask_wr), .set(stb.mask_set),
    .clr(stb.mask_clr), .wbits(wbits), .mask(mask)
  );

  hirq_status #(.IRQ_W(IRQ_W), .IMPL(IMPL)) status_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .ack(stb.ack_wr),
    .ack_bits(wbits), .take(stb.take_rd), .status(status)
  );

  hirq_out #(.IRQ_W(IRQ_W)) out_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(stb.ctrl_wr),
    .ctrl_bits(bus_wdata[CTRL_W-1:0]), .status(status), .mask(mask),
    .ctrl(ctrl), .irq(irq_o)
  );

  // R3: a peek alone leaves status untouched
  a_r3_peek_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.peek_rd && evt_i == '0 && !stb.ack_wr) |=> $stable(status));

  // R9: a disabled line rests at its idle level
  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |-> (irq_o == ctrl.active_low));

  // R9: with everything masked the line is idle
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask) == '0) |-> (irq_o == ctrl.active_low));

  // R1: the mask comes out of reset at its reset value
  a_r1_mask_after_reset: assert property (@(posedge clk)
    !rst_n |=> (mask == MASK_RST));

endmodule

// File: tb/hirq_ctrl_tb_top.sv
module hirq_ctrl_tb_top;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IRQ_W  = 18;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_EV  = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  4'd0, 32'h0,        32'h1,     8'd1},  // R1 mask reset
    '{OP_RD,  4'd3, 32'h0,        32'h0,     8'd1},  // R1 status reset
    '{OP_RD,  4'd6, 32'h0,        32'h0,     8'd1},  // R1 control reset
    '{OP_IRQ, 4'd0, 32'h0,        32'h0,     8'd1},  // R1 line idle
    '{OP_EV,  4'd0, 32'h3FFFF,    32'h0,     8'd2},  // R2 all sources
    '{OP_RD,  4'd3, 32'h0,        32'h347FF, 8'd2},  // R2 reserved dropped
    '{OP_RD,  4'd3, 32'h0,        32'h347FF, 8'd3},  // R3 peek again
    '{OP_WR,  4'd5, 32'h3,        32'h0,     8'd5},
    '{OP_RD,  4'd3, 32'h0,        32'h347FC, 8'd5},  // R5 ack two bits
    '{OP_WR,  4'd5, 32'h0,        32'h0,     8'd5},
    '{OP_RD,  4'd3, 32'h0,        32'h347FC, 8'd5},  // R5 zero ack
    '{OP_RD,  4'd4, 32'h0,        32'h347FC, 8'd4},  // R4 take
    '{OP_RD,  4'd3, 32'h0,        32'h0,     8'd4},  // R4 cleared
    '{OP_WR,  4'd0, 32'h30F0F,    32'h0,     8'd6},
    '{OP_RD,  4'd0, 32'h0,        32'h30F0F, 8'd6},  // R6 direct
    '{OP_WR,  4'd1, 32'hF0,       32'h0,     8'd7},
    '{OP_RD,  4'd0, 32'h0,        32'h30FFF, 8'd7},  // R7 set
    '{OP_WR,  4'd2, 32'h20F00,    32'h0,     8'd8},
    '{OP_RD,  4'd0, 32'h0,        32'h100FF, 8'd8},  // R8 clear
    '{OP_WR,  4'd0, 32'hFFFFFFFF, 32'h0,     8'd6},
    '{OP_RD,  4'd0, 32'h0,        32'h3FFFF, 8'd6},  // R6 upper dropped
    '{OP_WR,  4'd0, 32'h1,        32'h0,     8'd6},
    '{OP_WR,  4'd6, 32'h1,        32'h0,     8'd9},
    '{OP_EV,  4'd0, 32'h1,        32'h0,     8'd9},
    '{OP_IRQ, 4'd0, 32'h0,        32'h0,     8'd9},  // R9 masked source
    '{OP_EV,  4'd0, 32'h4,        32'h0,     8'd9},
    '{OP_IRQ, 4'd0, 32'h0,        32'h1,     8'd9},  // R9 unmasked source
    '{OP_WR,  4'd6, 32'h3,        32'h0,     8'd9},
    '{OP_IRQ, 4'd0, 32'h0,        32'h0,     8'd9},  // R9 active low
    '{OP_WR,  4'd5, 32'h4,        32'h0,     8'd9},
    '{OP_IRQ, 4'd0, 32'h0,        32'h1,     8'd9},  // R9 low idle
    '{OP_WR,  4'd6, 32'h0,        32'h0,     8'd9},
    '{OP_IRQ, 4'd0, 32'h0,        32'h0,     8'd9},  // R9 disabled
    '{OP_RD,  4'd1, 32'h0,        32'h0,     8'd10}, // R10 write-only
    '{OP_RD,  4'd7, 32'h0,        32'h0,     8'd10}, // R10 unmapped
    '{OP_WR,  4'd5, 32'h3FFFF,    32'h0,     8'd5},
    '{OP_RD,  4'd3, 32'h0,        32'h0,     8'd5}   // R5 all acked
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [IRQ_W-1:0]  evt_i = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rd_en = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    evt_i = e[IRQ_W-1:0];
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      case (VEC[i].op)
        OP_WR:  bus_write(VEC[i].addr, VEC[i].data);
        OP_RD:  begin bus_read(VEC[i].addr, rd); check(tag, rd, VEC[i].exp); end
        OP_EV:  pulse(VEC[i].data);
        default: check(tag, {31'b0, irq_o}, VEC[i].exp);
      endcase
    end

    // R4: take colliding with an event keeps the event, word excludes it
    pulse(32'h3);
    bus_addr = 4'd4; bus_rd_en = 1'b1; evt_i = 18'h10;
    @(negedge clk);
    bus_rd_en = 1'b0; evt_i = '0;
    check("R4", bus_rdata, 32'h3);
    bus_read(4'd3, rd);
    check("R4", rd, 32'h10);

    // R5: acknowledge colliding with an event on the same bit loses
    bus_addr = 4'd5; bus_wdata = 32'h10; bus_wr_en = 1'b1; evt_i = 18'h10;
    @(negedge clk);
    bus_wr_en = 1'b0; evt_i = '0;
    bus_read(4'd3, rd);
    check("R5", rd, 32'h10);

    // R10: read word held while no read is issued
    @(negedge clk);
    check("R10", bus_rdata, 32'h10);

    // R1: reset mid-run restores mask, status and line
    bus_write(4'd0, 32'h0);
    bus_write(4'd6, 32'h1);
    check("R9", {31'b0, irq_o}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(4'd0, rd);
    check("R1", rd, 32'h1);
    bus_read(4'd3, rd);
    check("R1", rd, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule